// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a bank of peripheral interrupt request lines and one reset request. It picks a winner by fixed priority and gives the CPU the program-memory address of that winner's vector. Each source is assigned a slot index. The reset request takes slot 0 and peripheral source `k` takes slot `k+1`. Every slot is two words wide, so a slot's address is its table base plus twice its index. A lower index always wins.

Each source has a pending flag that latches a request pulse. Delivery of a pending source needs three things: its own enable bit, the global enable, and no block from the code-region lock. The interrupt table sits at address 0 by default and can be moved to the boot-section base `BOOT_BASE`. The reset vector has its own independent relocation control. The lock can block interrupt delivery while the program counter lies in the application region (below `BOOT_BASE`) or in the boot region (at or above it).

When the CPU acknowledges, the controller clears the global enable and the serviced pending flag. A return-from-interrupt pulse turns the global enable back on.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A peripheral source is delivered only when its pending flag, its `irq_en_i` bit and the global enable `gie_o` are all 1; with `gie_o` at 0 no peripheral request reaches `req_o`.
- R2: The reset request uses slot index 0 and source `k` uses slot index `k+1`; `src_o` carries the slot index and `vec_o` = table base + 2 × index.
- R3: With `ivt_boot_i` = 0 and `rst_boot_i` = 0 every table base is 0.
- R4: Among deliverable sources the lowest slot index wins; the reset request always wins and ignores the global enable, the per-source enables and the lock.
- R5: `ivt_boot_i` = 1 moves the peripheral vectors to base `BOOT_BASE` and leaves the reset vector unchanged.
- R6: `rst_boot_i` = 1 moves the reset vector to `BOOT_BASE` and leaves the peripheral vectors unchanged.
- R7: With `lock_app_i` = 1 peripheral delivery is blocked while `pc_i` < `BOOT_BASE`. With `lock_boot_i` = 1 it is blocked while `pc_i` >= `BOOT_BASE`. Pending flags are kept through the block.
- R8: A request pulse sets the source's pending flag (`pend_o` bit k). The flag holds while the source is disabled and clears on `irq_clr_i`. A request in the same cycle as a clear leaves the flag set.
- R9: An `ack_i` while `req_o` = 1 clears `gie_o` and the serviced source's pending flag. `reti_i` sets `gie_o`, and the acknowledge wins if both arrive together. `gie_we_i` writes `gie_wd_i` to the global enable.
- R10: `req_o`, `src_o` and `vec_o` are registers that reflect the inputs and state sampled at the previous clock edge. A higher-priority request arriving before the acknowledge replaces the lower one on the next edge.
- R11: After reset `req_o`, `src_o`, `vec_o`, `gie_o` and `pend_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | N_SRC | Peripheral request pulses, bit k = source k |
| irq_en_i | input | N_SRC | Per-source enable bits |
| irq_clr_i | input | N_SRC | Software clear of pending flags |
| rst_req_i | input | 1 | Reset request, highest priority |
| gie_we_i | input | 1 | Write strobe for the global enable |
| gie_wd_i | input | 1 | Value written to the global enable |
| reti_i | input | 1 | Return from interrupt, sets the global enable |
| ack_i | input | 1 | CPU acknowledges the current request |
| ivt_boot_i | input | 1 | Peripheral table at boot base |
| rst_boot_i | input | 1 | Reset vector at boot base |
| pc_i | input | ADDR_W | Current program counter |
| lock_app_i | input | 1 | Block interrupts while executing in the application region |
| lock_boot_i | input | 1 | Block interrupts while executing in the boot region |
| req_o | output | 1 | Request to the CPU |
| src_o | output | IDX_W | Slot index of the winner |
| vec_o | output | ADDR_W | Vector address of the winner |
| gie_o | output | 1 | Global enable state |
| pend_o | output | N_SRC | Pending flags |

## Verification
The main test sweeps all 256 pending patterns of the eight sources. The sweep is repeated under four enable masks and both table placements. This separates a priority encoder that picks the wrong end from one that ignores the enables. It also catches a base or slot stride that is off. Directed sequences then combine the reset request with each relocation setting, place the program counter on each side of the region boundary under each lock, and follow an acknowledge and return pair. This shows whether pending state survives blocking, clearing and preemption by a newer, higher-priority request.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic {
    REGION_APP  = 1'b0,
    REGION_BOOT = 1'b1
  } region_e;
endpackage

// File: rtl/vic_pending.sv
module vic_pending #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_q_o,
  output logic [N_SRC-1:0] pend_d_o
);
  for (genvar k = 0; k < N_SRC; k++) begin : g_bit
    logic q;
    // set beats clear so a fresh pulse is never lost
    assign pend_d_o[k] = set_i[k] | (q & ~clr_i[k]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= pend_d_o[k];
    end
    assign pend_q_o[k] = q;

    AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q && !clr_i[k]) |=> q); // R8
    AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> q); // R8
  end
endmodule

// File: rtl/vic_lock_gate.sv
module vic_lock_gate
  import vic_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BOOT_BASE = 'hE00
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              lock_app_i,
  input  logic              lock_boot_i,
  output logic              block_o
);
  localparam logic [ADDR_W-1:0] BootB = ADDR_W'(BOOT_BASE);
  region_e region;

  always_comb begin
    region  = (pc_i >= BootB) ? REGION_BOOT : REGION_APP;
    unique case (region)
      REGION_APP:  block_o = lock_app_i;
      REGION_BOOT: block_o = lock_boot_i;
      default:     block_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
  parameter int unsigned N_IN  = 9,
  parameter int unsigned IDX_W = $clog2(N_IN)
) (
  input  logic [N_IN-1:0]  req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    valid_o = |req_i;
    idx_o   = '0;
    // scan downwards so the lowest set bit is the one left
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vic_vec_gen.sv
module vic_vec_gen #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned BOOT_BASE = 'hE00
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              ivt_boot_i,
  input  logic              rst_boot_i,
  output logic [ADDR_W-1:0] vec_o
);
  localparam logic [ADDR_W-1:0] BootB = ADDR_W'(BOOT_BASE);
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offs;

  always_comb begin
    if (idx_i == '0) base = rst_boot_i ? BootB : '0;
    else             base = ivt_boot_i ? BootB : '0;
    offs  = ADDR_W'({idx_i, 1'b0});
    vec_o = base + offs;
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int unsigned N_SRC     = 8,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BOOT_BASE = 'hE00,
  localparam int unsigned N_SLOT   = N_SRC + 1,
  localparam int unsigned IDX_W    = $clog2(N_SLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_req_i,
  input  logic [N_SRC-1:0]  irq_en_i,
  input  logic [N_SRC-1:0]  irq_clr_i,
  input  logic              rst_req_i,
  input  logic              gie_we_i,
  input  logic              gie_wd_i,
  input  logic              reti_i,
  input  logic              ack_i,
  input  logic              ivt_boot_i,
  input  logic              rst_boot_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              lock_app_i,
  input  logic              lock_boot_i,
  output logic              req_o,
  output logic [IDX_W-1:0]  src_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic              gie_o,
  output logic [N_SRC-1:0]  pend_o
);
  localparam logic [ADDR_W-1:0] BootB = ADDR_W'(BOOT_BASE);

  logic              req_q, gie_q, gie_d, take, blocked, sel_valid;
  logic [IDX_W-1:0]  src_q, sel_idx;
  logic [ADDR_W-1:0] vec_q, sel_vec;
  logic [N_SRC-1:0]  ack_clr, pend_q, pend_d, eligible;

  assign take = ack_i & req_q;

  for (genvar k = 0; k < N_SRC; k++) begin : g_ackclr
    assign ack_clr[k] = take && (src_q == IDX_W'(k + 1));
  end

  vic_pending #(.N_SRC(N_SRC)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (irq_req_i),
    .clr_i    (irq_clr_i | ack_clr),
    .pend_q_o (pend_q),
    .pend_d_o (pend_d)
  );

  always_comb begin
    if (take)          gie_d = 1'b0;
    else if (reti_i)   gie_d = 1'b1;
    else if (gie_we_i) gie_d = gie_wd_i;
    else               gie_d = gie_q;
  end

  vic_lock_gate #(.ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE)) u_lock (
    .pc_i        (pc_i),
    .lock_app_i  (lock_app_i),
    .lock_boot_i (lock_boot_i),
    .block_o     (blocked)
  );

  assign eligible = pend_d & irq_en_i & {N_SRC{gie_d & ~blocked}};

  vic_prio_enc #(.N_IN(N_SLOT), .IDX_W(IDX_W)) u_prio (
    .req_i   ({eligible, rst_req_i}),
    .valid_o (sel_valid),
    .idx_o   (sel_idx)
  );

  vic_vec_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BOOT_BASE(BOOT_BASE)) u_vec (
    .idx_i      (sel_idx),
    .ivt_boot_i (ivt_boot_i),
    .rst_boot_i (rst_boot_i),
    .vec_o      (sel_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q <= 1'b0;
      req_q <= 1'b0;
      src_q <= '0;
      vec_q <= '0;
    end else begin
      gie_q <= gie_d;
      req_q <= sel_valid;
      src_q <= sel_valid ? sel_idx : '0;
      vec_q <= sel_valid ? sel_vec : '0;
    end
  end

  assign req_o  = req_q;
  assign src_o  = src_q;
  assign vec_o  = vec_q;
  assign gie_o  = gie_q;
  assign pend_o = pend_q;

  AST_REQ_NEEDS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && src_o != '0) |-> gie_o); // R1
  AST_RESET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> (req_o && src_o == '0)); // R4
  AST_RST_VEC_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && src_o == '0) |-> (vec_o == '0 || vec_o == BootB)); // R6
  AST_LOCK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blocked && !rst_req_i) |=> !req_o); // R7
  AST_ACK_DROPS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && req_o) |=> !gie_o); // R9
  AST_SRC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (int'(src_o) < N_SLOT)); // R2
endmodule

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;
  localparam int N   = 8;
  localparam int AW  = 12;
  localparam int BB  = 'hE00;
  localparam int IW  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_req = '0, irq_en = '0, irq_clr = '0;
  logic          rst_req = 1'b0, gie_we = 1'b0, gie_wd = 1'b0, reti = 1'b0, ack = 1'b0;
  logic          ivt_boot = 1'b0, rst_boot = 1'b0, lock_app = 1'b0, lock_boot = 1'b0;
  logic [AW-1:0] pc = '0;
  logic          req, gie;
  logic [IW-1:0] src;
  logic [AW-1:0] vec;
  logic [N-1:0]  pend;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vec_irq_ctrl #(.N_SRC(N), .ADDR_W(AW), .BOOT_BASE(BB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq_req), .irq_en_i(irq_en),
    .irq_clr_i(irq_clr), .rst_req_i(rst_req), .gie_we_i(gie_we), .gie_wd_i(gie_wd),
    .reti_i(reti), .ack_i(ack), .ivt_boot_i(ivt_boot), .rst_boot_i(rst_boot),
    .pc_i(pc), .lock_app_i(lock_app), .lock_boot_i(lock_boot),
    .req_o(req), .src_o(src), .vec_o(vec), .gie_o(gie), .pend_o(pend)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string r, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  // req/src/vec packed into one comparison
  function automatic int pack(logic rq, logic [IW-1:0] s, logic [AW-1:0] v);
    return (int'(rq) << 20) | (int'(s) << 16) | int'(v);
  endfunction

  function automatic int expect_irq(int elig, bit ivt);
    int idx;
    if (elig == 0) return 0;
    idx = 0;
    for (int i = N - 1; i >= 0; i--) if (elig[i]) idx = i + 1;
    return (1 << 20) | (idx << 16) | ((ivt ? BB : 0) + 2 * idx);
  endfunction

  task automatic clear_all();
    irq_req = '0; irq_clr = '1; step(); irq_clr = '0;
  endtask

  task automatic pulse(logic [N-1:0] p);
    irq_req = p; step(); irq_req = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int en_set [4] = '{'hFF, 'h0F, 'hA5, 'h5A};
    @(negedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11", "req/src/vec", pack(req, src, vec), 0);
    chk("R11", "gie", int'(gie), 0);
    chk("R11", "pend", int'(pend), 0);
    rst_n = 1'b1;
    step();

    gie_we = 1; gie_wd = 1; step(); gie_we = 0; gie_wd = 0;
    chk("R9", "gie write", int'(gie), 1);

    // R1 R2 R3 R4 R5 sweep over pending patterns, enables, table placement
    for (int t = 0; t < 2; t++) begin
      ivt_boot = t[0];
      for (int e = 0; e < 4; e++) begin
        irq_en = N'(en_set[e]);
        for (int p = 0; p < 256; p++) begin
          clear_all();
          pulse(N'(p));
          chk(t == 0 ? "R3" : "R5", "sweep R1 R2 R4",
              pack(req, src, vec), expect_irq(p & en_set[e], t[0]));
        end
      end
    end
    ivt_boot = 0; irq_en = '1;

    // R1 global enable off blocks peripherals
    clear_all();
    gie_we = 1; gie_wd = 0; step(); gie_we = 0;
    pulse(8'h10); step();
    chk("R1", "gie off", int'(req), 0);
    gie_we = 1; gie_wd = 1; step(); gie_we = 0;
    chk("R1", "gie on", pack(req, src, vec), expect_irq('h10, 0));

    // R4 R6 reset request with relocation combos, gie off
    for (int rb = 0; rb < 2; rb++) begin
      for (int ib = 0; ib < 2; ib++) begin
        gie_we = 1; gie_wd = 0; step(); gie_we = 0;
        rst_boot = rb[0]; ivt_boot = ib[0]; irq_en = '0;
        rst_req = 1; step(); rst_req = 0;
        chk("R6", "reset vector", pack(req, src, vec),
            (1 << 20) | (rb == 1 ? BB : 0));
      end
    end
    rst_boot = 0; ivt_boot = 0; irq_en = '1;
    gie_we = 1; gie_wd = 1; step(); gie_we = 0;
    // R4 reset beats a pending source
    pulse(8'h01); rst_req = 1; step(); rst_req = 0;
    chk("R4", "reset over src0", pack(req, src, vec), 1 << 20);

    // R7 lock by region, pending kept
    clear_all();
    pulse(8'h04);
    lock_app = 1; pc = AW'(BB - 1); step();
    chk("R7", "app lock app pc", int'(req), 0);
    pc = AW'(BB); step();
    chk("R7", "app lock boot pc", pack(req, src, vec), expect_irq('h04, 0));
    lock_app = 0; lock_boot = 1; step();
    chk("R7", "boot lock boot pc", int'(req), 0);
    chk("R7", "pend kept", int'(pend), 'h04);
    pc = '0; step();
    chk("R7", "boot lock app pc", pack(req, src, vec), expect_irq('h04, 0));
    lock_boot = 0;

    // R8 pending held while disabled, cleared by software, set wins
    clear_all();
    irq_en = '0; pulse(8'h08); step(); step();
    chk("R8", "held disabled", int'(pend), 'h08);
    chk("R8", "no req disabled", int'(req), 0);
    irq_en = '1; step();
    chk("R8", "req after enable", pack(req, src, vec), expect_irq('h08, 0));
    irq_clr = 8'h08; step(); irq_clr = '0;
    chk("R8", "sw clear", int'(pend), 0);
    irq_clr = 8'h02; irq_req = 8'h02; step(); irq_clr = '0; irq_req = '0;
    chk("R8", "set beats clear", int'(pend), 'h02);

    // R9 acknowledge and return
    clear_all();
    pulse(8'h24);
    chk("R9", "pre-ack", pack(req, src, vec), expect_irq('h04, 0));
    ack = 1; reti = 1; step(); ack = 0; reti = 0;
    chk("R9", "ack gie", int'(gie), 0);
    chk("R9", "ack pend", int'(pend), 'h20);
    chk("R9", "ack req", int'(req), 0);
    reti = 1; step(); reti = 0;
    chk("R9", "reti", pack(req, src, vec), expect_irq('h20, 0));
    chk("R9", "reti gie", int'(gie), 1);

    // R10 higher priority replaces lower before ack
    clear_all();
    pulse(8'h40);
    chk("R10", "low first", pack(req, src, vec), expect_irq('h40, 0));
    pulse(8'h02);
    chk("R10", "replaced", pack(req, src, vec), expect_irq('h42, 0));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule